// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter

This block decides which of several bus masters owns one slave port of a crossbar. Every master raises a request line toward the slave. Each master also has a small priority value that can be written at run time. When more than one master asks for the slave, the one with the largest priority value takes the port. It keeps the port until its transaction ends. The other requesters see a stall indication and hold their requests until they are served.

Several masters can share the top priority value. In that case the winner is chosen in rotating order, starting from the master that follows the one granted most recently. The grant is registered: it appears one cycle after the decision. A decision is made only while the slave is free, or in the cycle where the current owner ends its transaction, so a multi-beat transfer is never broken up. An owner that withdraws its request without signalling the end is treated as having finished.

The arbiter sits beside the address and data multiplexers of the crossbar. Those paths are 32 bits wide. They are steered by the one-hot grant and the encoded owner index, but they are not part of this block.

Top module: `xbar_slave_arb`

## Requirements
- R1: After reset no grant is active, `gnt_valid` is 0, every priority value is 0, and the most-recently-granted pointer holds master N-1, so master 0 wins the first tie.
- R2: A request that reaches an idle slave produces a grant to a requesting master on the next clock edge. `gnt` never has more than one bit set.
- R3: Among requesters in an arbitration cycle, a master with a numerically larger priority value wins (3 is highest, 0 is lowest for the 2-bit default).
- R4: When several requesters share the largest priority value, the winner is the first of them in the order last+1, last+2, ... (modulo N). Here "last" is the most recently granted master.
- R5: While the owner keeps its request asserted and does not assert its done bit, the grant does not change. Requests from other masters (even higher-priority ones) and done bits from non-owners have no effect.
- R6: In a cycle where the owner asserts its done bit, arbitration runs again over all current requesters, including the owner. The new grant, or no grant if nobody requests, shows on the next edge.
- R7: An owner that drops its request without asserting done is treated as finished. Arbitration runs in that cycle, and the next grant excludes that master.
- R8: `stall[i]` is 1 exactly when master i requests and does not hold the grant.
- R9: A write with `cfg_we`=1 sets the priority of master `cfg_id` to `cfg_pri`. It applies to arbitration from the following cycle and never disturbs a held grant.
- R10: `gnt_valid` is 1 exactly when a grant is active, and `gnt_id` then gives the index of the granted bit. `gnt_id` is 0 when no grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Per-master request for the slave |
| done | input | N | Per-master end-of-transaction strobe, honoured only from the owner |
| cfg_we | input | 1 | Priority write enable |
| cfg_id | input | $clog2(N) | Master whose priority is written |
| cfg_pri | input | PW | New priority value |
| gnt | output | N | One-hot ownership grant |
| gnt_valid | output | 1 | A grant is active |
| gnt_id | output | $clog2(N) | Index of the owning master |
| stall | output | N | Master requests but does not own the slave |

## Verification
A corrupted rotation pointer does not show until a later tie: the wrong master is granted one cycle after that tie is resolved. The rotation scenarios therefore build ties right after known grants. A wrong priority value is hidden until two requesters with different values meet. A lost owner register shows at once as a dropped or moved grant during a held transfer. The behavioural model compares every output on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

   // Variant used to break a tie among equal top-priority requesters
   typedef enum logic {
      TIE_FIXED  = 1'b0,   // lowest index wins
      TIE_ROTATE = 1'b1    // rotate after the last granted master
   } tie_mode_e;

   // Width of an index able to name n masters (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xbar_arb_prio_regs.sv
module xbar_arb_prio_regs #(
   parameter int N   = 4,
   parameter int PW  = 2,
   parameter int IDW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDW-1:0]  wr_sel,
   input  logic [PW-1:0]   wr_val,
   output logic [N*PW-1:0] prio_flat
);

   for (genvar m = 0; m < N; m++) begin : g_reg
      logic [PW-1:0] level_q;
      logic          hit;

      assign hit = wr_en && (wr_sel == IDW'(m));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= '0;
         end else if (hit) begin
            level_q <= wr_val;
         end
      end

      assign prio_flat[m*PW +: PW] = level_q;
   end

endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick
   import xbar_arb_pkg::*;
#(
   parameter int        N        = 4,
   parameter int        PW       = 2,
   parameter int        IDW      = 2,
   parameter tie_mode_e TIE_MODE = TIE_ROTATE
) (
   input  logic [N-1:0]    req,
   input  logic [N*PW-1:0] prio_flat,
   input  logic [IDW-1:0]  last_id,
   output logic            win_valid,
   output logic [IDW-1:0]  win_id
);

   logic [PW-1:0] top_level;
   logic [N-1:0]  contender;

   // Largest priority value among current requesters
   always_comb begin
      top_level = '0;
      for (int m = 0; m < N; m++) begin
         if (req[m] && (prio_flat[m*PW +: PW] > top_level)) begin
            top_level = prio_flat[m*PW +: PW];
         end
      end
   end

   for (genvar m = 0; m < N; m++) begin : g_cont
      assign contender[m] = req[m] && (prio_flat[m*PW +: PW] == top_level);
   end

   assign win_valid = |req;

   if (TIE_MODE == TIE_ROTATE) begin : g_rotate
      // Scan from the farthest position back to last+1 so the nearest wins
      always_comb begin
         win_id = '0;
         for (int k = N; k >= 1; k--) begin
            int pos;
            pos = int'(last_id) + k;
            if (pos >= N) pos = pos - N;
            if (contender[pos]) win_id = IDW'(pos);
         end
      end
   end else begin : g_fixed
      always_comb begin
         win_id = '0;
         for (int m = N - 1; m >= 0; m--) begin
            if (contender[m]) win_id = IDW'(m);
         end
      end
   end

endmodule

// File: rtl/xbar_arb_owner.sv
module xbar_arb_owner #(
   parameter int N   = 4,
   parameter int IDW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   input  logic [N-1:0]   done,
   input  logic           win_valid,
   input  logic [IDW-1:0] win_id,
   output logic [IDW-1:0] last_id,
   output logic [N-1:0]   gnt,
   output logic           gnt_valid,
   output logic [IDW-1:0] gnt_id
);

   logic           own_v_q;
   logic [IDW-1:0] own_id_q;
   logic [IDW-1:0] last_q;
   logic           release_now;

   // Slave free, owner finished, or owner withdrew its request
   assign release_now = !own_v_q || done[own_id_q] || !req[own_id_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_v_q  <= 1'b0;
         own_id_q <= '0;
         last_q   <= IDW'(N - 1);
      end else if (release_now) begin
         own_v_q <= win_valid;
         if (win_valid) begin
            own_id_q <= win_id;
            last_q   <= win_id;
         end
      end
   end

   for (genvar m = 0; m < N; m++) begin : g_gnt
      assign gnt[m] = own_v_q && (own_id_q == IDW'(m));
   end

   assign gnt_valid = own_v_q;
   assign gnt_id    = own_v_q ? own_id_q : '0;
   assign last_id   = last_q;

endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
   import xbar_arb_pkg::*;
#(
   parameter int        N        = 4,
   parameter int        PW       = 2,
   parameter tie_mode_e TIE_MODE = TIE_ROTATE,
   localparam int       IDW      = idx_width(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   input  logic [N-1:0]   done,
   input  logic           cfg_we,
   input  logic [IDW-1:0] cfg_id,
   input  logic [PW-1:0]  cfg_pri,
   output logic [N-1:0]   gnt,
   output logic           gnt_valid,
   output logic [IDW-1:0] gnt_id,
   output logic [N-1:0]   stall
);

   // Elaboration-time parameter checks
   if (N < 2) begin : g_bad_n
      $error("xbar_slave_arb: N must be at least 2");
   end
   if (PW < 1) begin : g_bad_pw
      $error("xbar_slave_arb: PW must be at least 1");
   end

   logic [N*PW-1:0] prio_flat;
   logic [IDW-1:0]  last_id;
   logic            win_valid;
   logic [IDW-1:0]  win_id;

   xbar_arb_prio_regs #(
      .N   (N),
      .PW  (PW),
      .IDW (IDW)
   ) prio_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_sel    (cfg_id),
      .wr_val    (cfg_pri),
      .prio_flat (prio_flat)
   );

   xbar_arb_pick #(
      .N        (N),
      .PW       (PW),
      .IDW      (IDW),
      .TIE_MODE (TIE_MODE)
   ) pick_i (
      .req       (req),
      .prio_flat (prio_flat),
      .last_id   (last_id),
      .win_valid (win_valid),
      .win_id    (win_id)
   );

   xbar_arb_owner #(
      .N   (N),
      .IDW (IDW)
   ) owner_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .done      (done),
      .win_valid (win_valid),
      .win_id    (win_id),
      .last_id   (last_id),
      .gnt       (gnt),
      .gnt_valid (gnt_valid),
      .gnt_id    (gnt_id)
   );

   assign stall = req & ~gnt;

endmodule

// File: rtl/xbar_slave_arb_chk.sv
module xbar_slave_arb_chk #(
   parameter int N   = 4,
   parameter int IDW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   req,
   input logic [N-1:0]   done,
   input logic [N-1:0]   gnt,
   input logic           gnt_valid,
   input logic [IDW-1:0] gnt_id
);

   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_idle_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|gnt) && (|req)) |=> (|gnt));

   assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|gnt) && !$stable(gnt)) |-> (|(gnt & $past(req))));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(gnt & req)) && !(|(gnt & done))) |=> $stable(gnt));

   assert_drop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|gnt) && !(|(gnt & req))) |=> !(|(gnt & $past(gnt))));

   assert_valid_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt[gnt_id] && (gnt_valid == (|gnt))));

endmodule

bind xbar_slave_arb xbar_slave_arb_chk #(
   .N   (N),
   .IDW (IDW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .done      (done),
   .gnt       (gnt),
   .gnt_valid (gnt_valid),
   .gnt_id    (gnt_id)
);

// File: tb/xbar_slave_arb_tb_top.sv
`timescale 1ns/1ps
module xbar_slave_arb_tb_top;

   localparam int NM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [3:0] done = '0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_id = '0;
   logic [1:0] cfg_pri = '0;
   logic [3:0] gnt;
   logic       gnt_valid;
   logic [1:0] gnt_id;
   logic [3:0] stall;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   string phase = "R1";

   // Reference state
   int m_owner = -1;
   int m_last = NM - 1;
   int m_pri [NM] = '{default: 0};

   always #5 clk = ~clk;

   xbar_slave_arb dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .done      (done),
      .cfg_we    (cfg_we),
      .cfg_id    (cfg_id),
      .cfg_pri   (cfg_pri),
      .gnt       (gnt),
      .gnt_valid (gnt_valid),
      .gnt_id    (gnt_id),
      .stall     (stall)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_pick(input logic [3:0] r);
      int best = -1;
      int best_p = -1;
      for (int k = 1; k <= NM; k++) begin
         int i = (m_last + k) % NM;
         if (r[i] && m_pri[i] > best_p) begin
            best = i;
            best_p = m_pri[i];
         end
      end
      return best;
   endfunction

   // Reference model advances on every edge
   always @(posedge clk) begin
      int w;
      if (!rst_n) begin
         m_owner = -1;
         m_last = NM - 1;
         for (int i = 0; i < NM; i++) m_pri[i] = 0;
      end else begin
         if (m_owner < 0 || done[m_owner] || !req[m_owner]) begin
            w = model_pick(req);
            m_owner = w;
            if (w >= 0) m_last = w;
         end
         if (cfg_we) m_pri[cfg_id] = int'(cfg_pri);
      end
   end

   // Compare every output on every cycle, away from the edge
   always @(negedge clk) begin
      logic [3:0] eg;
      if (rst_n) begin
         eg = (m_owner >= 0) ? 4'(1 << m_owner) : 4'b0000;
         check({phase, " gnt model"}, 32'(gnt), 32'(eg));
         check({phase, " gnt_valid model R10"}, 32'(gnt_valid), 32'(m_owner >= 0));
         check({phase, " gnt_id model R10"}, 32'(gnt_id), (m_owner >= 0) ? 32'(m_owner) : 32'd0);
         check({phase, " stall model R8"}, 32'(stall), 32'(req & ~eg));
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         miscompares++;
         $display("FAIL watchdog expired actual %0d cycles expected < 50000", cycles);
         finish_run();
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_pri(input int id, input int p);
      cfg_we = 1'b1;
      cfg_id = 2'(id);
      cfg_pri = 2'(p);
      tick();
      cfg_we = 1'b0;
   endtask

   initial begin
      // R1 reset state
      tick();
      tick();
      check("R1 gnt in reset", 32'(gnt), 0);
      check("R1 gnt_valid in reset", 32'(gnt_valid), 0);
      check("R1 stall in reset", 32'(stall), 0);
      rst_n = 1'b1;
      tick();
      check("R1 gnt idle after reset", 32'(gnt), 0);

      // R1/R4: first tie goes to master 0, then rotation on each done (R6)
      phase = "R4";
      req = 4'b1111;
      tick();
      check("R1 first tie winner", 32'(gnt), 32'h1);
      done = 4'b0001; tick(); check("R4 rotate to 1", 32'(gnt), 32'h2);
      done = 4'b0010; tick(); check("R4 rotate to 2", 32'(gnt), 32'h4);
      done = 4'b0100; tick(); check("R4 rotate to 3", 32'(gnt), 32'h8);
      done = 4'b1000; tick(); check("R4 wrap to 0", 32'(gnt), 32'h1);
      done = 4'b0000; req = 4'b0000;
      tick();
      check("R7 drop without done idles", 32'(gnt), 0);

      // R9/R3: priorities
      phase = "R3";
      set_pri(2, 3);
      set_pri(1, 2);
      req = 4'b1111;
      tick();
      check("R3 highest priority wins", 32'(gnt), 32'h4);
      check("R8 stall of losers", 32'(stall), 32'hB);
      check("R10 gnt_id", 32'(gnt_id), 2);
      check("R10 gnt_valid", 32'(gnt_valid), 1);
      done = 4'b0100;
      tick();
      check("R6 owner re-wins on done", 32'(gnt), 32'h4);
      req = 4'b1011;
      tick();
      check("R6 next priority after done", 32'(gnt), 32'h2);

      // R5: hold despite higher priority and foreign done
      phase = "R5";
      done = 4'b0000;
      set_pri(3, 3);
      check("R9 write does not disturb owner", 32'(gnt), 32'h2);
      done = 4'b1000;
      tick();
      check("R5 foreign done ignored", 32'(gnt), 32'h2);
      tick();
      check("R5 still held", 32'(gnt), 32'h2);
      done = 4'b0010;
      tick();
      check("R9 new priority used", 32'(gnt), 32'h8);

      // R7: owner withdraws without done
      phase = "R7";
      done = 4'b0000;
      req = 4'b0011;
      tick();
      check("R7 withdraw rearbitrates", 32'(gnt), 32'h2);

      // R6: done with nobody waiting
      phase = "R6";
      req = 4'b0000;
      done = 4'b0010;
      tick();
      check("R6 idle after last done", 32'(gnt), 0);
      check("R10 gnt_id when idle", 32'(gnt_id), 0);
      done = 4'b0000;

      // R4: tie inside a subset, rotation starts after last (master 1)
      phase = "R4";
      for (int i = 0; i < NM; i++) set_pri(i, 1);
      req = 4'b1001;
      tick();
      check("R4 subset tie after last", 32'(gnt), 32'h8);
      done = 4'b1000;
      tick();
      check("R4 subset wrap", 32'(gnt), 32'h1);
      done = 4'b0000;
      req = 4'b0000;
      tick();

      // R2..R10: long mixed traffic against the model
      phase = "R2 mixed";
      for (int n = 0; n < 4000; n++) begin
         tick();
         for (int i = 0; i < NM; i++) begin
            if (gnt[i]) begin
               if (($urandom % 16) == 0) begin
                  req[i] = 1'b0;
                  done[i] = 1'b0;
               end else begin
                  done[i] = (($urandom % 3) == 0);
                  if (done[i] && ($urandom % 2) == 0) req[i] = 1'b0;
               end
            end else begin
               done[i] = (($urandom % 8) == 0);
               if (!req[i]) req[i] = (($urandom % 3) == 0);
            end
         end
         cfg_we = (($urandom % 8) == 0);
         cfg_id = 2'($urandom % 4);
         cfg_pri = 2'($urandom % 4);
      end
      cfg_we = 1'b0;
      req = '0;
      done = '0;
      tick();
      tick();
      finish_run();
   end

endmodule